// File: doc/BRIEF.md
# Serial PROM Sync-Search Byte Reader

This block pulls user data out of a bit-serial configuration memory whose user payload sits behind the configuration image. It generates the memory's serial clock from the system clock and samples the serial data line. It shifts the incoming bits through a window as wide as the synchronisation word until the window matches that word. The sync word is an input port, so the caller sets the marker that separates the image from the payload.

Once the marker is found, the reader announces it with a one-cycle low pulse. It then collects the next eight bits, most significant bit first, and presents them as a byte with a one-cycle low ready pulse. Every later byte is fetched only when the consumer gives a one-cycle low read pulse. Between bytes the serial clock is parked low, so no memory bit is skipped and the presented byte stays unchanged. A one-cycle low resync pulse abandons the current stream position and starts a new hunt for the marker.

A synchronous active-high reset restarts the search. While it is high, the reader also holds the memory's reset/output-enable line high, which rewinds the memory to its first bit.

Top module: `serial_prom_reader`

## Requirements
- R1: While `rst` is high, the outputs settle to `prom_rst`=1, `sclk`=0, `sync_n`=1, `rdy_n`=1 and `byte_out`=0, including after a stream has already delivered bytes.
- R2: While the reader is fetching bits, `sclk` runs at a quarter of `clk`, high for two cycles and low for two cycles.
- R3: `sync_n` is low for exactly one cycle. It falls together with the `sclk` rising edge that samples the last bit of the first window equal to `sync_word`. The window compares the most recent 2^SYNC_LOG2 bits, with the oldest bit at the MSB.
- R4: With no read request, the 8 bits after the marker are delivered as one byte, first-received bit at bit 7. `rdy_n` is low for one cycle and coincides with the `sclk` rise that samples bit 0, and `byte_out` carries the byte in that cycle.
- R5: After a byte is delivered, `sclk` produces no rising edge and `rdy_n` stays high until a read pulse or a resync pulse arrives.
- R6: A one-cycle low pulse on `rd_n` while the reader is parked fetches the next byte with exactly eight `sclk` rising edges.
- R7: `byte_out` changes only in a cycle where `rdy_n` is low.
- R8: A one-cycle low pulse on `resync_n` discards the current position. No byte is delivered until the next occurrence of `sync_word` in the stream has been signalled on `sync_n`.
- R9: The marker is whatever value `sync_word` holds. A stream containing a different 32-bit word does not produce a sync.
- R10: `prom_rst` falls one cycle after `rst` is released, and the hunt starts from the first bit the memory presents after that.
- R11: `rd_n` pulses are ignored while the reader is hunting or collecting a byte. Such a pulse causes neither an extra byte nor extra `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; release starts a new hunt |
| rd_n | input | 1 | Active-low one-cycle request for the next byte |
| resync_n | input | 1 | Active-low one-cycle request to hunt for the marker again; tie high if unused |
| sdin | input | 1 | Serial data from the memory |
| sync_word | input | 2^SYNC_LOG2 | Marker pattern searched for in the bit stream |
| sclk | output | 1 | Serial clock to the memory |
| sync_n | output | 1 | Active-low one-cycle marker-found strobe |
| rdy_n | output | 1 | Active-low one-cycle byte-ready strobe |
| prom_rst | output | 1 | Active-high reset/output-enable line to the memory |
| byte_out | output | 8 | Most recently delivered byte |

## Verification
A wrong bit counter or a shift-window slip appears at the ports as a sync or ready strobe that comes some `sclk` rises early or late, or as a byte with rotated bits. Counting rising edges from reset release or from a read pulse therefore exposes it at the first strobe, within a few dozen serial clocks. A controller stuck in the wrong state shows up as `sclk` edges while the reader should be parked, or as a missing ready strobe after a read. Either becomes visible within one byte period of about 32 system cycles.

// File: rtl/prom_rdr_pkg.sv
package prom_rdr_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2
  } rdr_state_t;
endpackage

// File: rtl/prom_sclk_gen.sv
module prom_sclk_gen #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic bit_stb
);
  localparam int RISE_I = (1 << (PH_W - 1)) - 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(RISE_I);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0] ph;
  logic            sclk_q;
  logic            active;

  // keep going until the current serial period is complete
  assign active  = run || (ph != '0);
  assign bit_stb = run && (ph == PH_RISE);
  assign sclk    = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      sclk_q <= 1'b0;
    end else if (active) begin
      ph <= ph + 1'b1;
      if (ph == PH_RISE)
        sclk_q <= 1'b1;
      else if (ph == PH_LAST)
        sclk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/prom_sync_hunt.sv
module prom_sync_hunt #(
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             sdin,
  input  logic [PAT_W-1:0] pattern,
  output logic             hit
);
  logic [PAT_W-1:0] win;
  logic [PAT_W-1:0] win_nxt;
  logic [PAT_W-1:0] bit_eq;

  assign win_nxt = {win[PAT_W-2:0], sdin};

  for (genvar g = 0; g < PAT_W; g++) begin : g_cmp
    assign bit_eq[g] = ~(win_nxt[g] ^ pattern[g]);
  end

  assign hit = shift_en && (&bit_eq);

  always_ff @(posedge clk) begin
    if (rst || clear)
      win <= '0;
    else if (shift_en)
      win <= win_nxt;
  end
endmodule

// File: rtl/prom_byte_ctrl.sv
module prom_byte_ctrl
  import prom_rdr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              sdin,
  input  logic              hit,
  input  logic              rd_n,
  input  logic              resync_n,
  output logic              run,
  output logic              hunt_en,
  output logic              hunt_clr,
  output logic              sync_n,
  output logic              rdy_n,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  rdr_state_t       st;
  logic [CNT_W-1:0] bcnt;
  logic [BYTE_W-1:0] bsh;
  logic [BYTE_W-1:0] byte_q;
  logic              sync_q;
  logic              rdy_q;

  assign run      = (st != ST_HOLD);
  assign hunt_en  = (st == ST_HUNT) && bit_stb && resync_n;
  assign hunt_clr = ~resync_n;
  assign sync_n   = sync_q;
  assign rdy_n    = rdy_q;
  assign byte_out = byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_HUNT;
      bcnt   <= '0;
      bsh    <= '0;
      byte_q <= '0;
      sync_q <= 1'b1;
      rdy_q  <= 1'b1;
    end else begin
      sync_q <= 1'b1;
      rdy_q  <= 1'b1;
      if (!resync_n) begin
        st   <= ST_HUNT;
        bcnt <= '0;
      end else begin
        case (st)
          ST_HUNT: begin
            if (hit) begin
              st     <= ST_FILL;
              bcnt   <= '0;
              sync_q <= 1'b0;
            end
          end
          ST_FILL: begin
            if (bit_stb) begin
              bsh  <= {bsh[BYTE_W-2:0], sdin};
              bcnt <= bcnt + 1'b1;
              if (bcnt == CNT_LAST) begin
                byte_q <= {bsh[BYTE_W-2:0], sdin};
                rdy_q  <= 1'b0;
                st     <= ST_HOLD;
              end
            end
          end
          ST_HOLD: begin
            if (!rd_n) begin
              st   <= ST_FILL;
              bcnt <= '0;
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_prom_reader.sv
module serial_prom_reader #(
  parameter int SYNC_LOG2 = 5,
  parameter int CLK_MHZ   = 50
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_n,
  input  logic                      resync_n,
  input  logic                      sdin,
  input  logic [(1<<SYNC_LOG2)-1:0] sync_word,
  output logic                      sclk,
  output logic                      sync_n,
  output logic                      rdy_n,
  output logic                      prom_rst,
  output logic [7:0]                byte_out
);
  localparam int PAT_W  = 1 << SYNC_LOG2;
  // divide by 4 at ordinary rates, by 8 on fast system clocks
  localparam int PH_W   = (CLK_MHZ > 100) ? 3 : 2;
  localparam int BYTE_W = 8;

  logic run, bit_stb, hunt_en, hunt_clr, hit;
  logic prom_rst_q;

  always_ff @(posedge clk) begin
    prom_rst_q <= rst;
  end
  assign prom_rst = prom_rst_q;

  prom_sclk_gen #(.PH_W(PH_W)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .sclk    (sclk),
    .bit_stb (bit_stb)
  );

  prom_sync_hunt #(.PAT_W(PAT_W)) u_hunt (
    .clk      (clk),
    .rst      (rst),
    .clear    (hunt_clr),
    .shift_en (hunt_en),
    .sdin     (sdin),
    .pattern  (sync_word),
    .hit      (hit)
  );

  prom_byte_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .sdin     (sdin),
    .hit      (hit),
    .rd_n     (rd_n),
    .resync_n (resync_n),
    .run      (run),
    .hunt_en  (hunt_en),
    .hunt_clr (hunt_clr),
    .sync_n   (sync_n),
    .rdy_n    (rdy_n),
    .byte_out (byte_out)
  );
endmodule

// File: rtl/prom_reader_chk.sv
module prom_reader_chk (
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       sync_n,
  input logic       rdy_n,
  input logic       prom_rst,
  input logic [7:0] byte_out
);
  AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |=> sclk); // R2
  AST_SCLK_LOW_TWO: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |=> !sclk); // R2
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) !sync_n |=> sync_n); // R3
  AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst) !sync_n |-> $rose(sclk)); // R3
  AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) !rdy_n |=> rdy_n); // R4
  AST_RDY_ON_RISE: assert property (@(posedge clk) disable iff (rst) !rdy_n |-> $rose(sclk)); // R4
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(byte_out) |-> !rdy_n); // R7
  AST_PROM_RST_DROP: assert property (@(posedge clk) disable iff (rst) !rst |=> !prom_rst); // R10
endmodule

bind serial_prom_reader prom_reader_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sclk     (sclk),
  .sync_n   (sync_n),
  .rdy_n    (rdy_n),
  .prom_rst (prom_rst),
  .byte_out (byte_out)
);

// File: tb/sim_serial_prom_reader.sv
`timescale 1ns/1ps
module sim_serial_prom_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_n = 1'b1;
  logic        resync_n = 1'b1;
  logic        sdin;
  logic [31:0] sync_word = 32'h8F9FAFBF;
  logic        sclk, sync_n, rdy_n, prom_rst;
  logic [7:0]  byte_out;

  int tests = 0;
  int fails = 0;
  int rises = 0;
  int ridx  = 0;
  int wptr  = 0;
  logic sclk_d = 1'b0;
  logic stream [0:1023];

  always #10 clk = ~clk;

  serial_prom_reader u0 (
    .clk(clk), .rst(rst), .rd_n(rd_n), .resync_n(resync_n), .sdin(sdin),
    .sync_word(sync_word), .sclk(sclk), .sync_n(sync_n), .rdy_n(rdy_n),
    .prom_rst(prom_rst), .byte_out(byte_out)
  );

  // memory model: next bit after each serial clock fall, rewound by prom_rst
  assign sdin = (ridx < 1024) ? stream[ridx] : 1'b1;

  always @(posedge clk) begin
    sclk_d <= sclk;
    if (sclk && !sclk_d) rises <= rises + 1;
    if (prom_rst === 1'b1) ridx <= 0;
    else if (!sclk && sclk_d) ridx <= ridx + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_stream();
    for (int i = 0; i < 1024; i++) stream[i] = 1'b1;
    wptr = 0;
  endtask

  task automatic push(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      stream[wptr] = v[i];
      wptr = wptr + 1;
    end
  endtask

  // which: 0 = sync_n, 1 = rdy_n
  task automatic wait_low(input int which, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ((which == 0 && !sync_n) || (which == 1 && !rdy_n)) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk) rd_n = 1'b1;
  endtask

  task automatic do_reset(output int base);
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(prom_rst == 1'b1 && sclk == 1'b0 && sync_n && rdy_n && byte_out == 8'h00,
        "R1 reset outputs", {prom_rst, sclk, sync_n, rdy_n, byte_out}, {4'b1011, 8'h00});
    base = rises;
    rst = 1'b0;
    @(negedge clk);
    chk(prom_rst == 1'b0, "R10 prom_rst release", prom_rst, 0);
  endtask

  // parked: no sclk rise, no ready, byte stable for a while
  task automatic check_parked(input logic [7:0] exp, input string req);
    int s;
    bit extra;
    extra = 1'b0;
    repeat (2) @(negedge clk);
    s = rises;
    repeat (40) begin
      @(negedge clk);
      if (!rdy_n) extra = 1'b1;
    end
    chk(rises == s, {req, " sclk parked"}, rises - s, 0);
    chk(!extra, {req, " no extra ready"}, extra, 0);
    chk(byte_out == exp, "R7 byte held", byte_out, exp);
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit extra_rd);
    int s;
    bit ok;
    s = rises;
    pulse_rd();
    if (extra_rd) begin
      repeat (3) @(negedge clk);
      pulse_rd();
    end
    wait_low(1, ok);
    chk(ok && byte_out == exp, "R6 read byte value", byte_out, exp);
    @(negedge clk);
    chk(rises - s == 8, "R6 eight sclk rises", rises - s, 8);
  endtask

  task automatic t_main();
    int base, s, p0, p1;
    bit ok;
    clear_stream();
    wptr = 13;
    push(32'h8F9FAFBF, 32);
    push(32'hA5, 8); push(32'h3C, 8); push(32'hFF, 8); push(32'h00, 8);
    sync_word = 32'h8F9FAFBF;
    do_reset(base);
    // serial clock period
    while (!(sclk && !sclk_d)) @(negedge clk);
    p0 = rises;
    repeat (4) @(negedge clk);
    p1 = rises;
    chk(p1 - p0 == 1, "R2 one sclk rise per 4 clocks", p1 - p0, 1);
    // a read pulse while hunting is ignored
    pulse_rd();
    wait_low(0, ok);
    chk(ok, "R3 sync seen", ok, 1);
    @(negedge clk);
    chk(sync_n == 1'b1, "R3 sync single cycle", sync_n, 1);
    chk(rises - base == 45, "R3 sync after 45 bits / R11 hunt ignores rd", rises - base, 45);
    wait_low(1, ok);
    chk(ok && byte_out == 8'hA5, "R4 first byte auto", byte_out, 8'hA5);
    @(negedge clk);
    chk(rdy_n == 1'b1, "R4 ready single cycle", rdy_n, 1);
    chk(rises - base == 53, "R4 eight bits after sync", rises - base, 53);
    check_parked(8'hA5, "R5");
    read_byte(8'h3C, 1'b0);
    check_parked(8'h3C, "R5");
    read_byte(8'hFF, 1'b1);
    check_parked(8'hFF, "R11");
    read_byte(8'h00, 1'b0);
    s = rises;
    chk(s > 0, "R2 sclk active", s, 1);
  endtask

  task automatic t_resync();
    int base, s;
    bit ok, early;
    clear_stream();
    push(32'h8F9FAFBF, 32);
    push(32'h11, 8); push(32'h22, 8); push(32'h33, 8);
    push(32'h8F9FAFBF, 32);
    push(32'h44, 8);
    sync_word = 32'h8F9FAFBF;
    do_reset(base);
    wait_low(1, ok);
    chk(ok && byte_out == 8'h11, "R8 byte before resync", byte_out, 8'h11);
    repeat (2) @(negedge clk);
    s = rises;
    @(negedge clk) resync_n = 1'b0;
    @(negedge clk) resync_n = 1'b1;
    early = 1'b0;
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!rdy_n) early = 1'b1;
      if (!sync_n) begin ok = 1'b1; break; end
    end
    chk(ok && !early, "R8 no byte before new sync", early, 0);
    @(negedge clk);
    chk(rises - s == 48, "R8 resync finds next marker", rises - s, 48);
    wait_low(1, ok);
    chk(ok && byte_out == 8'h44, "R8 byte after new marker", byte_out, 8'h44);
  endtask

  task automatic t_pattern();
    int base;
    bit ok;
    clear_stream();
    push(32'h8F9FAFBF, 32);
    push(32'h0000FFFF, 32);
    push(32'h5A, 8);
    sync_word = 32'h0000FFFF;
    do_reset(base);
    wait_low(0, ok);
    @(negedge clk);
    chk(ok && rises - base == 64, "R9 programmed marker only", rises - base, 64);
    wait_low(1, ok);
    chk(ok && byte_out == 8'h5A, "R9 byte after programmed marker", byte_out, 8'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_stream();
    repeat (3) @(negedge clk);
    chk(prom_rst == 1'b1 && sclk == 1'b0 && sync_n && rdy_n, "R1 initial reset",
        {prom_rst, sclk, sync_n, rdy_n}, 4'b1011);
    t_main();
    t_resync();
    t_pattern();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule